// File: doc/BRIEF.md
# Sticky Interrupt Request Register

This peripheral holds one 32-bit control word behind an AXI4-Lite slave port and turns a single-cycle event pulse from surrounding logic into a level interrupt request for a processor core. Once raised, the request stays up until software writes it back to zero, so a short event is never missed while the core is busy elsewhere.

Software can also raise the request by writing a one into the flag bit. This lets one core interrupt another through the same register. The upper 31 bits have no effect on the interrupt. They act as scratch storage that reads back whatever was last written to them. The interrupt output is active low.

Top module: `irqflag_top`

## Requirements
- R1: After reset, the whole register reads 0x00000000 and the interrupt output `irq_n` is high.
- R2: A one-cycle high pulse on `evt_tick` sets bit 0. From the cycle after the pulse's clock edge, `irq_n` is low.
- R3: A bus write with bit 0 = 1 and strobe lane 0 set sets bit 0 and drives `irq_n` low.
- R4: Only a bus write with bit 0 = 0 and strobe lane 0 set clears bit 0. A tick never clears it, and a tick while bit 0 is already set leaves it set.
- R5: When a tick and a clearing write take effect on the same clock edge, bit 0 ends up 1.
- R6: Bits 31:1 are plain storage. A read returns the value last written to them, and they never affect `irq_n`.
- R7: Each byte lane i (bits 8i+7:8i) is updated only when `s_wstrb[i]` is 1. Bit 0 changes through the bus only when `s_wstrb[0]` is 1.
- R8: `irq_n` is 0 exactly when bit 0 of the register is 1, one register stage from the stored bit.
- R9: Every write and read completes with response OKAY (2'b00). Each path holds at most one outstanding transaction: `s_awready`/`s_wready` are low while `s_bvalid` is high, and `s_arready` is low while `s_rvalid` is high.
- R10: The write address and write data may arrive in either order or together. The write takes effect once both have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tick | input | 1 | Synchronous event pulse that raises the request |
| s_awaddr | input | ADDR_W | Write address (ignored, single register) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (ignored, single register) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The flag bit is driven by ticks alone, by software set and clear writes alone, and by a tick landing on the same edge as a clearing write. Together these show whether setting is sticky, whether only the bus can clear, and whether the tick wins a collision. Writes with partial strobes and with varied scratch patterns separate lane gating from plain storage, and show that the scratch bits stay away from the interrupt. Address-first, data-first and simultaneous write orderings, plus a held-off response ready, exercise the handshake and the single-outstanding rule.

// File: rtl/irqflag_pkg.sv
package irqflag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam logic [1:0]  RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    WR_IDLE = 2'b00,
    WR_HAVE = 2'b01,
    WR_RESP = 2'b10
  } wr_state_e;
endpackage

// File: rtl/irqflag_wr_if.sv
module irqflag_wr_if
  import irqflag_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic              aw_got_q, aw_got_d;
  logic              w_got_q, w_got_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [STRB_W-1:0] stb_q, stb_d;
  logic              bv_q, bv_d;
  logic              aw_fire, w_fire, commit;

  assign awready = !aw_got_q && !bv_q;
  assign wready  = !w_got_q && !bv_q;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign commit  = (aw_got_q || aw_fire) && (w_got_q || w_fire);

  always_comb begin
    aw_got_d = aw_got_q;
    w_got_d  = w_got_q;
    dat_d    = dat_q;
    stb_d    = stb_q;
    bv_d     = bv_q;
    if (aw_fire) aw_got_d = 1'b1;
    if (w_fire) begin
      w_got_d = 1'b1;
      dat_d   = wdata;
      stb_d   = wstrb;
    end
    if (commit) begin
      aw_got_d = 1'b0;
      w_got_d  = 1'b0;
      bv_d     = 1'b1;
    end else if (bv_q && bready) begin
      bv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      dat_q    <= '0;
      stb_q    <= '0;
      bv_q     <= 1'b0;
    end else begin
      aw_got_q <= aw_got_d;
      w_got_q  <= w_got_d;
      bv_q     <= bv_d;
      if (w_fire) begin
        dat_q <= dat_d;
        stb_q <= stb_d;
      end
    end
  end

  assign wr_en   = commit;
  assign wr_data = w_fire ? wdata : dat_q;
  assign wr_strb = w_fire ? wstrb : stb_q;
  assign bvalid  = bv_q;
  assign bresp   = RESP_OKAY;

  logic unused_addr;
  assign unused_addr = ^awaddr;

  // R9: one outstanding write, response held until taken
  a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (!awready && !wready));
  a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
endmodule

// File: rtl/irqflag_rd_if.sv
module irqflag_rd_if
  import irqflag_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] reg_val
);
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              ar_fire;

  assign arready = !rv_q;
  assign ar_fire = arvalid && arready;

  always_comb begin
    rv_d = rv_q;
    rd_d = rd_q;
    if (ar_fire) begin
      rv_d = 1'b1;
      rd_d = reg_val;
    end else if (rv_q && rready) begin
      rv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (ar_fire) rd_q <= rd_d;
    end
  end

  assign rvalid = rv_q;
  assign rdata  = rd_q;
  assign rresp  = RESP_OKAY;

  logic unused_addr;
  assign unused_addr = ^araddr;

  // R9: one outstanding read, data stable until taken
  a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);
  a_r9_r_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/irqflag_regfile.sv
module irqflag_regfile
  import irqflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  output logic [DATA_W-1:0] reg_val,
  output logic              irq_n
);
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic              irqn_q;

  generate
    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
      if (g == 0) begin : g_low
        always_comb begin
          ctl_d[7:1] = (wr_en && wr_strb[0]) ? wr_data[7:1] : ctl_q[7:1];
          if (evt_tick)                    ctl_d[0] = 1'b1;
          else if (wr_en && wr_strb[0])    ctl_d[0] = wr_data[0];
          else                             ctl_d[0] = ctl_q[0];
        end
      end else begin : g_hi
        always_comb begin
          ctl_d[8*g+7:8*g] = (wr_en && wr_strb[g]) ? wr_data[8*g+7:8*g]
                                                   : ctl_q[8*g+7:8*g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      irqn_q <= 1'b1;
    end else begin
      ctl_q  <= ctl_d;
      irqn_q <= !ctl_d[0];
    end
  end

  assign reg_val = ctl_q;
  assign irq_n   = irqn_q;

  // R8: output tracks the stored flag
  a_r8_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !reg_val[0]);
  // R2: tick always sets the flag
  a_r2_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tick |=> reg_val[0]);
  // R4: flag drops only through a lane-0 write
  a_r4_clear_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_val[0]) |-> $past(wr_en && wr_strb[0] && !wr_data[0]));
  // R7: untouched upper lane holds
  a_r7_lane3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_strb[3]) |=> $stable(reg_val[31:24]));
endmodule

// File: rtl/irqflag_top.sv
module irqflag_top
  import irqflag_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_tick,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              irq_n
);
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [DATA_W-1:0] reg_val;

  irqflag_wr_if #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  irqflag_rd_if #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .reg_val(reg_val)
  );

  irqflag_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .evt_tick(evt_tick),
    .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb),
    .reg_val(reg_val), .irq_n(irq_n)
  );

  // R9: responses are always OKAY
  a_r9_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid -> s_bresp == RESP_OKAY) && (s_rvalid -> s_rresp == RESP_OKAY));
endmodule

// File: tb/irqflag_tb_top.sv
module irqflag_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_tick = 1'b0;
  logic [11:0] s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic        s_arvalid = 1'b0, s_rready = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, irq_n;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd;
  logic [1:0]  rr;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqflag_top dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive just after an edge; sample before the next
  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // mode 0 together, 1 address first, 2 data first
  task automatic bus_write(logic [31:0] d, logic [3:0] s, int mode = 0);
    logic [1:0] br;
    if (mode != 2) s_awvalid = 1'b1;
    if (mode != 1) begin s_wvalid = 1'b1; s_wdata = d; s_wstrb = s; end
    if (mode != 0) begin
      step();
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      if (mode == 1) begin s_wvalid = 1'b1; s_wdata = d; s_wstrb = s; end
      else s_awvalid = 1'b1;
    end
    step();
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    check("R9 bvalid", {31'd0, s_bvalid}, 32'd1);
    br = s_bresp;
    check("R9 bresp", {30'd0, br}, 32'd0);
    s_bready = 1'b1;
    step();
    s_bready = 1'b0;
  endtask

  task automatic bus_read(output logic [31:0] d, output logic [1:0] r);
    s_arvalid = 1'b1;
    step();
    s_arvalid = 1'b0;
    d = s_rdata; r = s_rresp;
    check("R9 rvalid", {31'd0, s_rvalid}, 32'd1);
    s_rready = 1'b1;
    step();
    s_rready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq_n", {31'd0, irq_n}, 32'd1);
    bus_read(rd, rr);
    check("R1 reset value", rd, 32'h0);
  endtask

  task automatic t_tick;
    evt_tick = 1'b1; step(); evt_tick = 1'b0;
    check("R2 irq_n low", {31'd0, irq_n}, 32'd0);
    step(3);
    check("R2 held", {31'd0, irq_n}, 32'd0);
    evt_tick = 1'b1; step(); evt_tick = 1'b0;
    check("R4 tick keeps set", {31'd0, irq_n}, 32'd0);
    bus_write(32'h0, 4'hF);
    check("R4 clear", {31'd0, irq_n}, 32'd1);
  endtask

  task automatic t_soft;
    bus_write(32'h1, 4'h1);
    check("R3 soft set", {31'd0, irq_n}, 32'd0);
    bus_read(rd, rr);
    check("R3 readback", rd, 32'h1);
    bus_write(32'h0, 4'hE);
    check("R7 no lane0 clear", {31'd0, irq_n}, 32'd0);
    bus_write(32'h0, 4'h1);
    check("R4 bus clear", {31'd0, irq_n}, 32'd1);
  endtask

  task automatic t_collide;
    bus_write(32'h1, 4'h1);
    // clear write lands on the same edge as a tick
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_wdata = 32'h0; s_wstrb = 4'h1;
    evt_tick = 1'b1;
    step();
    s_awvalid = 1'b0; s_wvalid = 1'b0; evt_tick = 1'b0;
    s_bready = 1'b1; step(); s_bready = 1'b0;
    check("R5 tick wins", {31'd0, irq_n}, 32'd0);
    bus_read(rd, rr);
    check("R5 bit0", {31'd0, rd[0]}, 32'd1);
    bus_write(32'h0, 4'h1);
  endtask

  task automatic t_scratch;
    bus_write(32'hA5C3_7E10, 4'hF, 1);
    check("R6 scratch no irq", {31'd0, irq_n}, 32'd1);
    bus_read(rd, rr);
    check("R6 readback", rd, 32'hA5C3_7E10);
    check("R9 rresp", {30'd0, rr}, 32'd0);
    bus_write(32'hFFFF_FFFE, 4'h6, 2);
    bus_read(rd, rr);
    check("R7 lanes 1,2", rd, 32'hA5FF_FF10);
    check("R10 both orders", {31'd0, irq_n}, 32'd1);
  endtask

  task automatic t_backpressure;
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_wdata = 32'h1; s_wstrb = 4'h1;
    step();
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    step(2);
    check("R9 awready low while resp", {31'd0, s_awready}, 32'd0);
    check("R9 wready low while resp", {31'd0, s_wready}, 32'd0);
    check("R9 bvalid held", {31'd0, s_bvalid}, 32'd1);
    s_bready = 1'b1; step(); s_bready = 1'b0;
    check("R9 awready back", {31'd0, s_awready}, 32'd1);
    check("R10 commit", {31'd0, irq_n}, 32'd0);
    s_arvalid = 1'b1; step(); s_arvalid = 1'b0;
    step();
    check("R9 arready low while rvalid", {31'd0, s_arready}, 32'd0);
    s_rready = 1'b1; step(); s_rready = 1'b0;
    bus_write(32'h0, 4'h1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_tick();
    t_soft();
    t_collide();
    t_scratch();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule